// File: doc/BRIEF.md
# SMRAM and TSEG Access Controller

This block guards the system-management memory of a host bridge. It holds two byte-wide control registers (a main SMRAM control byte and an extended control byte) plus a 16-bit extended-size query register, all written through a byte-wide configuration port with per-register write masks. A sticky lock bit, once set, clears the open bit and freezes both control bytes until reset.

For every memory access the block takes the system address and a flag telling whether the requester is in system-management mode. It returns one of three routes: DRAM, the PCI/VGA space, or an all-ones hole. It covers three regions: the legacy window at 0xA0000–0xBFFFF, a high alias of that window at 0xFEDA0000–0xFEDBFFFF, and a TSEG region that ends at the top of low memory. For a DRAM route it also gives the DRAM address. For the high alias that address is shifted down onto the legacy window. Routes are combinational from the current register state and the access inputs.

Top module: `smram_guard`

## Requirements
- R1: After reset the main control byte (cfg_addr 0) reads 0x02, the extended control byte (cfg_addr 1) reads 0x00, and the extended-size register (cfg_addr 2 low byte, 3 high byte) reads 0xFFFF.
- R2: Main control byte: bit 6 is open, bit 4 is lock and bit 3 is global enable, and only these bits are writable. Extended control byte: bit 7 is high enable, bits 2:1 are the TSEG size code and bit 0 is TSEG enable, and only these bits are writable. Other bits keep their values. A write takes effect on the next clock edge.
- R3: A write that sets lock also clears open in the same update. From then until reset, writes to cfg_addr 0 and 1 change nothing, and lock stays set.
- R4: Outside SMM, a legacy-window access routes to DRAM only when open is set and high enable is clear. Otherwise it routes to PCI.
- R5: Outside SMM, a high-alias access routes to DRAM when open and high enable are both set, with dram_addr = addr − 0xFED00000. Otherwise it routes to PCI.
- R6: In SMM with global enable set, the legacy window routes to DRAM when high enable is clear, and the high alias routes to DRAM (translated as in R5) when high enable is set. In any other case an SMM access routes as a non-SMM access would.
- R7: TSEG is active only when TSEG enable and global enable are both set. Size codes 0, 1 and 2 give 1, 2 and 8 MB. Code 3 gives EXT_MB megabytes. The region spans [TOP_LOW − size, TOP_LOW).
- R8: Inside an active TSEG, a non-SMM access routes to the hole and hole_rdata is all ones. An SMM access routes to DRAM at the unchanged address.
- R9: If a byte write leaves the extended-size register at 0xFFFF and EXT_MB is nonzero, the register instead takes the value EXT_MB.
- R10: Route codes are 0 for DRAM, 1 for PCI and 2 for the hole. An address in no guarded region routes to DRAM below TOP_LOW and to PCI at or above it, with dram_addr equal to the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 2 | Register select: 0 main, 1 extended, 2/3 size low/high |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| acc_addr | input | 32 | Access system address |
| acc_smm | input | 1 | Access issued in system-management mode |
| route | output | 2 | Route decision (R10 encoding) |
| dram_addr | output | 32 | DRAM address for a DRAM route |
| hole_rdata | output | 32 | All ones when routed to the hole, else zero |

## Verification
A configuration write is captured on the clock edge while cfg_we is high. Its effect shows on cfg_rdata and on the routes from that edge onward, so it is due one cycle after the strobe. The bench drives each write on a falling edge, removes it on the next falling edge, and checks only after that point. Routes, dram_addr and hole_rdata are combinational from the access inputs. The bench sets the address and the SMM flag and samples a short delay later, away from any rising edge.

// File: rtl/smg_pkg.sv
package smg_pkg;
    typedef enum logic [1:0] {
        RT_DRAM = 2'd0,
        RT_PCI  = 2'd1,
        RT_HOLE = 2'd2
    } route_e;

    typedef struct packed {
        logic       open;
        logic       lock;
        logic       gen;
        logic       hse;
        logic [1:0] code;
        logic       ten;
    } flags_t;

    localparam logic [31:0] LEG_BASE  = 32'h000A_0000;
    localparam logic [31:0] LEG_END   = 32'h000C_0000;
    localparam logic [31:0] HI_BASE   = 32'hFEDA_0000;
    localparam logic [31:0] HI_END    = 32'hFEDC_0000;
    localparam logic [31:0] HI_SHIFT  = HI_BASE - LEG_BASE;

    localparam logic [7:0] MAIN_RST   = 8'h02;
    localparam logic [7:0] EXT_RST    = 8'h00;
    localparam logic [7:0] MAIN_MASK  = 8'h58;
    localparam logic [7:0] EXT_MASK   = 8'h87;
    localparam logic [15:0] SIZE_QRY  = 16'hFFFF;
endpackage

// File: rtl/smg_cfg.sv
module smg_cfg
    import smg_pkg::*;
#(
    parameter int EXT_MB = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output flags_t     flags
);
    localparam logic [15:0] EXT_VAL = 16'(EXT_MB);

    typedef struct packed {
        logic [7:0]  main;
        logic [7:0]  ext;
        logic [15:0] size;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        logic [7:0]  mmask;
        logic [7:0]  emask;
        logic [15:0] nsize;
        st_d  = st_q;
        mmask = st_q.main[4] ? 8'h00 : MAIN_MASK;
        emask = st_q.main[4] ? 8'h00 : EXT_MASK;
        nsize = st_q.size;
        if (cfg_we) begin
            case (cfg_addr)
                2'd0: begin
                    st_d.main = (st_q.main & ~mmask) | (cfg_wdata & mmask);
                    if (st_d.main[4]) st_d.main[6] = 1'b0;
                end
                2'd1: st_d.ext = (st_q.ext & ~emask) | (cfg_wdata & emask);
                2'd2: nsize[7:0]  = cfg_wdata;
                default: nsize[15:8] = cfg_wdata;
            endcase
            if (cfg_addr[1]) begin
                st_d.size = (nsize == SIZE_QRY && EXT_MB != 0) ? EXT_VAL : nsize;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{main: MAIN_RST, ext: EXT_RST, size: SIZE_QRY};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (cfg_addr)
            2'd0:    cfg_rdata = st_q.main;
            2'd1:    cfg_rdata = st_q.ext;
            2'd2:    cfg_rdata = st_q.size[7:0];
            default: cfg_rdata = st_q.size[15:8];
        endcase
    end

    assign flags.open = st_q.main[6];
    assign flags.lock = st_q.main[4];
    assign flags.gen  = st_q.main[3];
    assign flags.hse  = st_q.ext[7];
    assign flags.code = st_q.ext[2:1];
    assign flags.ten  = st_q.ext[0];
endmodule

// File: rtl/smg_route.sv
module smg_route
    import smg_pkg::*;
#(
    parameter logic [31:0] TOP_LOW = 32'h8000_0000,
    parameter int          EXT_MB  = 16
) (
    input  flags_t      flags,
    input  logic [31:0] acc_addr,
    input  logic        acc_smm,
    output route_e      route,
    output logic [31:0] dram_addr
);
    localparam logic [31:0] EXT_BYTES = 32'(EXT_MB) << 20;

    logic [31:0] tsize;
    logic        t_hit;
    logic        leg_hit;
    logic        hi_hit;
    logic        low_open;
    logic        hi_open;

    always_comb begin
        case (flags.code)
            2'd0:    tsize = 32'h0010_0000;
            2'd1:    tsize = 32'h0020_0000;
            2'd2:    tsize = 32'h0080_0000;
            default: tsize = EXT_BYTES;
        endcase
    end

    assign t_hit   = flags.ten && flags.gen && (tsize != 32'd0) &&
                     (acc_addr >= TOP_LOW - tsize) && (acc_addr < TOP_LOW);
    assign leg_hit = (acc_addr >= LEG_BASE) && (acc_addr < LEG_END);
    assign hi_hit  = (acc_addr >= HI_BASE) && (acc_addr < HI_END);

    // Windows visible to this requester
    assign low_open = (flags.open && !flags.hse) ||
                      (acc_smm && flags.gen && !flags.hse);
    assign hi_open  = (flags.open && flags.hse) ||
                      (acc_smm && flags.gen && flags.hse);

    always_comb begin
        dram_addr = acc_addr;
        if (t_hit) begin
            route = acc_smm ? RT_DRAM : RT_HOLE;
        end else if (leg_hit) begin
            route = low_open ? RT_DRAM : RT_PCI;
        end else if (hi_hit) begin
            route = hi_open ? RT_DRAM : RT_PCI;
            if (hi_open) dram_addr = acc_addr - HI_SHIFT;
        end else begin
            route = (acc_addr < TOP_LOW) ? RT_DRAM : RT_PCI;
        end
    end
endmodule

// File: rtl/smram_guard.sv
module smram_guard
    import smg_pkg::*;
#(
    parameter logic [31:0] TOP_LOW    = 32'h8000_0000,
    parameter int          EXT_MB     = 16,
    parameter int          EXT_MB_MAX = 4095
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_smm,
    output logic [1:0]  route,
    output logic [31:0] dram_addr,
    output logic [31:0] hole_rdata
);
    generate
        if (EXT_MB > EXT_MB_MAX || EXT_MB < 0) begin : g_bad_ext
            $error("EXT_MB outside the permitted range");
        end
    endgenerate

    flags_t flags;
    route_e route_w;

    smg_cfg #(.EXT_MB(EXT_MB)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .flags    (flags)
    );

    smg_route #(.TOP_LOW(TOP_LOW), .EXT_MB(EXT_MB)) u_route (
        .flags    (flags),
        .acc_addr (acc_addr),
        .acc_smm  (acc_smm),
        .route    (route_w),
        .dram_addr(dram_addr)
    );

    assign route      = route_w;
    assign hole_rdata = {32{route_w == RT_HOLE}};
endmodule

// File: rtl/smg_chk.sv
module smg_chk
    import smg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input flags_t      flags,
    input logic [31:0] acc_addr,
    input logic        acc_smm,
    input logic [1:0]  route,
    input logic [31:0] hole_rdata
);
    logic leg;
    assign leg = (acc_addr >= LEG_BASE) && (acc_addr < LEG_END);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags.lock |=> flags.lock);

    // R3
    lock_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags.lock |-> !flags.open);

    // R3
    lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags.lock |=> $stable(flags));

    // R8
    hole_nonsmm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_smm |-> route != 2'd2);

    // R8
    hole_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route == 2'd2 |-> hole_rdata == 32'hFFFF_FFFF);

    // R6
    smm_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_smm && leg && !flags.gen && !flags.open) |-> route == 2'd1);
endmodule

bind smram_guard smg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags     (flags),
    .acc_addr  (acc_addr),
    .acc_smm   (acc_smm),
    .route     (route),
    .hole_rdata(hole_rdata)
);

// File: tb/sim_smram_guard.sv
`timescale 1ns/100ps
module sim_smram_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic [31:0] acc_addr = 32'd0;
    logic        acc_smm = 1'b0;
    logic [1:0]  route;
    logic [31:0] dram_addr;
    logic [31:0] hole_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] DR = 2'd0, PC = 2'd1, HO = 2'd2;

    always #2.5 clk = ~clk;

    smram_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_addr(acc_addr),
        .acc_smm(acc_smm), .route(route), .dram_addr(dram_addr),
        .hole_rdata(hole_rdata)
    );

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        cfg_addr = a;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s reg %0d got %02h exp %02h", req, a, cfg_rdata, exp);
        end
    endtask

    task automatic chk_rt(input logic [31:0] a, input logic smm, input logic [1:0] er,
                          input logic [31:0] ed, input string req);
        acc_addr = a; acc_smm = smm;
        #1;
        checks++;
        if (route !== er || (er == DR && dram_addr !== ed) ||
            hole_rdata !== {32{er == HO}}) begin
            fails++;
            $display("FAIL %s addr %08h smm %0b got route %0d dram %08h hole %08h exp route %0d dram %08h",
                     req, a, smm, route, dram_addr, hole_rdata, er, ed);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk_rd(2'd0, 8'h02, "R1");
        chk_rd(2'd1, 8'h00, "R1");
        chk_rd(2'd2, 8'hFF, "R1");
        chk_rd(2'd3, 8'hFF, "R1");
        chk_rt(32'h000A_0000, 1'b0, PC, 32'h0, "R4 reset");
        chk_rt(32'h000B_FFFF, 1'b1, PC, 32'h0, "R6 reset");
        chk_rt(32'h0010_0000, 1'b0, DR, 32'h0010_0000, "R10");
        chk_rt(32'h8000_0000, 1'b0, PC, 32'h0, "R10");
    endtask

    task automatic t_masks();
        wr(2'd0, 8'hA7);        // only bits 6..3 mask 0x58 -> 0x02 kept, none of 0x58 set
        chk_rd(2'd0, 8'h02, "R2");
        wr(2'd0, 8'hFF & ~8'h10); // open, gen set, lock clear
        chk_rd(2'd0, 8'h4A, "R2");
        wr(2'd1, 8'hFF);
        chk_rd(2'd1, 8'h87, "R2");
        wr(2'd1, 8'h00);
        chk_rd(2'd1, 8'h00, "R2");
    endtask

    task automatic t_windows();
        // open=1 gen=1 hse=0
        wr(2'd0, 8'h48);
        chk_rt(32'h000A_1234, 1'b0, DR, 32'h000A_1234, "R4 open low");
        chk_rt(32'hFEDA_0010, 1'b0, PC, 32'h0, "R5 hse clear");
        chk_rt(32'hFEDA_0010, 1'b1, PC, 32'h0, "R6 smm hse clear");
        // hse=1
        wr(2'd1, 8'h80);
        chk_rt(32'h000A_1234, 1'b0, PC, 32'h0, "R4 hidden");
        chk_rt(32'hFEDB_FFFC, 1'b0, DR, 32'h000B_FFFC, "R5 alias");
        chk_rt(32'hFEDC_0000, 1'b0, PC, 32'h0, "R10 past alias");
        // open=0 gen=1 hse=1
        wr(2'd0, 8'h08);
        chk_rt(32'hFEDA_0000, 1'b0, PC, 32'h0, "R5 closed");
        chk_rt(32'hFEDA_0000, 1'b1, DR, 32'h000A_0000, "R6 smm high");
        chk_rt(32'h000A_0000, 1'b1, PC, 32'h0, "R6 smm low with hse");
        wr(2'd1, 8'h00);
        chk_rt(32'h000B_0000, 1'b1, DR, 32'h000B_0000, "R6 smm low");
        chk_rt(32'h000B_0000, 1'b0, PC, 32'h0, "R4 closed");
        wr(2'd0, 8'h00);
        chk_rt(32'h000B_0000, 1'b1, PC, 32'h0, "R6 gen off");
    endtask

    task automatic t_tseg();
        wr(2'd1, 8'h01);          // ten, code 0, gen still 0
        chk_rt(32'h7FF0_0000, 1'b0, DR, 32'h7FF0_0000, "R7 gen off");
        wr(2'd0, 8'h08);
        chk_rt(32'h7FF0_0000, 1'b0, HO, 32'h0, "R8 1MB base");
        chk_rt(32'h7FEF_FFFF, 1'b0, DR, 32'h7FEF_FFFF, "R7 below 1MB");
        chk_rt(32'h7FFF_FFFF, 1'b1, DR, 32'h7FFF_FFFF, "R8 smm");
        wr(2'd1, 8'h03);          // 2MB
        chk_rt(32'h7FE0_0000, 1'b0, HO, 32'h0, "R7 2MB");
        wr(2'd1, 8'h05);          // 8MB
        chk_rt(32'h7F80_0000, 1'b0, HO, 32'h0, "R7 8MB");
        chk_rt(32'h7F7F_FFFF, 1'b0, DR, 32'h7F7F_FFFF, "R7 8MB edge");
        wr(2'd1, 8'h07);          // EXT_MB = 16
        chk_rt(32'h7F00_0000, 1'b0, HO, 32'h0, "R7 ext");
        chk_rt(32'h7EFF_FFFF, 1'b0, DR, 32'h7EFF_FFFF, "R7 ext edge");
        wr(2'd1, 8'h00);
        chk_rt(32'h7FF0_0000, 1'b0, DR, 32'h7FF0_0000, "R7 ten off");
    endtask

    task automatic t_query();
        wr(2'd2, 8'hFF);
        chk_rd(2'd2, 8'h10, "R9");
        chk_rd(2'd3, 8'h00, "R9");
        wr(2'd3, 8'h12);
        chk_rd(2'd3, 8'h12, "R9 plain");
        chk_rd(2'd2, 8'h10, "R9 plain");
    endtask

    task automatic t_lock();
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h58);          // open+lock+gen -> open cleared
        chk_rd(2'd0, 8'h1A, "R3");
        wr(2'd0, 8'h40);
        chk_rd(2'd0, 8'h1A, "R3 frozen main");
        wr(2'd1, 8'h07);
        chk_rd(2'd1, 8'h80, "R3 frozen ext");
        chk_rt(32'hFEDA_0000, 1'b0, PC, 32'h0, "R3 no alias");
        do_reset();
        chk_rd(2'd0, 8'h02, "R3 reset clears");
    endtask

    initial begin
        do_reset();
        t_reset();
        t_masks();
        t_windows();
        t_tseg();
        t_query();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule